// File: doc/BRIEF.md
# Flow-Through Burst SRAM with Dual Address Strobes

This block is a single-port synchronous memory with 36-bit words. Each word is split into four 9-bit lanes. The depth is a parameter. Every control input and the write data are sampled on the rising clock edge.

A transfer can be opened by two strobes: one for the processor and one for the cache controller. The processor strobe has the higher priority. A 2-bit burst counter then steps through four consecutive locations. A static select input picks the counter order: XOR (interleaved) or modulo-4 addition (linear). The advance input moves the counter forward. When advance is high, the burst holds at the current location.

Read data is flow-through. The word at the address in force after a clock edge appears on the data output in the same cycle, before the next edge. A sleep request takes the memory through a two-edge entry and a two-edge exit. The stored contents are kept during sleep.

Control is a six-state machine:
- `ST_DESEL`: idle or deselected.
- `ST_READ`: read cycle.
- `ST_WRITE`: write cycle.
- `ST_DOZE`: first edge of sleep entry.
- `ST_SLEEP`: asleep.
- `ST_WAKE`: first edge of sleep exit.

Transitions:
- Awake states: a qualified strobe with the select pattern goes to `ST_READ` or `ST_WRITE`. A strobe without the select pattern goes to `ST_DESEL`. With no strobe, a burst cycle goes to `ST_READ` or `ST_WRITE` according to the write inputs. `ST_DESEL` with no strobe stays put.
- Any awake state, or `ST_WAKE`, with a sleep request goes to `ST_DOZE`.
- `ST_DOZE` goes to `ST_SLEEP` if the request persists, otherwise to `ST_DESEL`.
- `ST_SLEEP` goes to `ST_WAKE` when the request drops.
- `ST_WAKE` goes to `ST_DESEL`.

Top module: `burst_sram_ft`

## Requirements
- R1: When both strobes are low and the processor strobe is qualified, only the processor strobe is honoured. The cycle is a read and the write inputs have no effect.
- R2: A strobe-started cycle selects the memory only if `en_a_n`=0, `en_b`=1 and `en_c_n`=0. Any other pattern deselects it, and the outputs stay off. The enables have no effect on cycles without a strobe.
- R3: The processor strobe is ignored while `en_a_n` is 1. With the controller strobe high, the burst then continues as if no strobe were present.
- R4: A cycle started by the processor strobe is always a read. Write inputs on later burst cycles perform writes.
- R5: A cycle started by the controller strobe (processor strobe high or not qualified) writes if a write is indicated, and reads otherwise.
- R6: A write is indicated when `wr_all_n`=0, which writes all four lanes. It is also indicated when `wr_lane_en_n`=0 and some `lane_pick_n[i]`=0; each such lane i, held in data bits [9i+8:9i], is then written. Unpicked lanes keep their contents.
- R7: On a strobe, address bits [1:0] load the burst start and the offset is cleared. On a burst cycle, `step_n`=0 advances the offset by one, modulo 4. `step_n`=1 reuses the current address.
- R8: With `order_xor`=1 the low address bits are start XOR offset. With `order_xor`=0 they are (start + offset) mod 4. The upper bits keep the loaded value, and the sequence wraps after four.
- R9: On a read with `out_en_n`=0, `rdata` shows the word at the address in force after the last edge, before the next edge, and `rdata_oe` is 1. Whenever `rdata_oe` is 0, `rdata` is zero.
- R10: Once a write occurs, the outputs stay off, even on later burst reads, until a read is started by a strobe.
- R11: On the first cycle of a read that begins from the deselected state, the outputs stay off even when `out_en_n`=0.
- R12: Sleep is entered on the second edge with `doze_req`=1 and left on the second edge with `doze_req`=0. During sleep, strobes are ignored and the outputs are off. The stored words are unchanged afterwards.
- R13: After reset the memory is deselected and `rdata_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| addr | input | AW | Word address, sampled on strobe cycles |
| cpu_strobe_n | input | 1 | Processor address strobe, active low, higher priority |
| ctl_strobe_n | input | 1 | Controller address strobe, active low |
| en_a_n | input | 1 | Select input, active low; also qualifies the processor strobe |
| en_b | input | 1 | Select input, active high |
| en_c_n | input | 1 | Select input, active low |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_lane_en_n | input | 1 | Per-lane write enable, active low |
| lane_pick_n | input | 4 | Lane selects, active low, bit i for lane i |
| order_xor | input | 1 | Burst order: 1 XOR, 0 linear |
| out_en_n | input | 1 | Output enable, active low |
| doze_req | input | 1 | Sleep request, active high |
| wdata | input | 36 | Write data |
| rdata | output | 36 | Flow-through read data, zero when not driven |
| rdata_oe | output | 1 | Read data valid/drive enable for this cycle |

## Verification
The bench builds the memory with 1024 words and four 9-bit lanes. This keeps full-word address checks cheap while leaving the upper address bits in play, so a burst wrap can be seen not to disturb them. With this depth every one of the sixteen lane-pick patterns can be written to its own word and read back. Each burst order can be walked one step past its wrap point.

// File: rtl/sram_pkg.sv
package sram_pkg;
    typedef enum logic [2:0] {
        ST_DESEL = 3'd0,
        ST_READ  = 3'd1,
        ST_WRITE = 3'd2,
        ST_DOZE  = 3'd3,
        ST_SLEEP = 3'd4,
        ST_WAKE  = 3'd5
    } sram_st_e;
endpackage

// File: rtl/sram_burst.sv
module sram_burst #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          order_xor,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] tgt_addr
);
    localparam int HW = AW - 2;

    logic [HW-1:0] hi_q;
    logic [1:0]    start_q;
    logic [1:0]    off_q;
    logic [1:0]    off_nx;
    logic [1:0]    low_cur;
    logic [1:0]    low_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q    <= '0;
            start_q <= 2'd0;
            off_q   <= 2'd0;
        end else if (load) begin
            hi_q    <= addr_in[AW-1:2];
            start_q <= addr_in[1:0];
            off_q   <= 2'd0;
        end else if (step) begin
            off_q   <= off_nx;
        end
    end

    always_comb begin
        off_nx  = off_q + 2'd1;
        low_cur = order_xor ? (start_q ^ off_q)  : (start_q + off_q);
        low_nx  = order_xor ? (start_q ^ off_nx) : (start_q + off_nx);
        cur_addr = {hi_q, low_cur};
        if (load)
            tgt_addr = addr_in;
        else if (step)
            tgt_addr = {hi_q, low_nx};
        else
            tgt_addr = cur_addr;
    end
endmodule

// File: rtl/sram_lanes.sv
module sram_lanes #(
    parameter int DEPTH = 1024,
    parameter int LANES = 4,
    parameter int LW    = 9
) (
    input  logic                     clk,
    input  logic [LANES-1:0]         we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [LANES*LW-1:0]      wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [LANES*LW-1:0]      rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LW-1:0] bank [DEPTH];
        always_ff @(posedge clk) begin
            if (we[g])
                bank[waddr] <= wdata[g*LW +: LW];
        end
        assign rdata[g*LW +: LW] = bank[raddr];
    end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_strobe_n,
    input  logic             ctl_strobe_n,
    input  logic             en_a_n,
    input  logic             en_b,
    input  logic             en_c_n,
    input  logic             step_n,
    input  logic             wr_all_n,
    input  logic             wr_lane_en_n,
    input  logic [LANES-1:0] lane_pick_n,
    input  logic             out_en_n,
    input  logic             doze_req,
    output logic             load,
    output logic             step,
    output logic [LANES-1:0] wr_lanes,
    output logic             rd_en,
    output sram_st_e         st
);
    sram_st_e         st_d;
    logic             lock_q, lock_d;
    logic             mask_q, mask_d;
    logic             awake, in_burst, cpu_go, ctl_go, new_ld, chosen;
    logic             do_wr;
    logic [LANES-1:0] lanes_req;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_DESEL;
            lock_q <= 1'b0;
            mask_q <= 1'b0;
        end else begin
            st     <= st_d;
            lock_q <= lock_d;
            mask_q <= mask_d;
        end
    end

    always_comb begin
        awake     = (st == ST_DESEL || st == ST_READ || st == ST_WRITE) && !doze_req;
        in_burst  = (st == ST_READ || st == ST_WRITE) && !doze_req;
        cpu_go    = awake && !cpu_strobe_n && !en_a_n;
        ctl_go    = awake && !ctl_strobe_n && !cpu_go;
        new_ld    = cpu_go || ctl_go;
        chosen    = !en_a_n && en_b && !en_c_n;
        if (!wr_all_n)
            lanes_req = '1;
        else if (!wr_lane_en_n)
            lanes_req = ~lane_pick_n;
        else
            lanes_req = '0;
        do_wr     = ((ctl_go && chosen) || (!new_ld && in_burst)) && (|lanes_req);
        st_d      = st;
        lock_d    = lock_q;
        mask_d    = 1'b0;
        unique case (st)
            ST_DESEL, ST_READ, ST_WRITE: begin
                if (doze_req)
                    st_d = ST_DOZE;
                else if (new_ld && !chosen)
                    st_d = ST_DESEL;
                else if (new_ld || in_burst)
                    st_d = do_wr ? ST_WRITE : ST_READ;
                if (!doze_req && new_ld && chosen && !do_wr) begin
                    lock_d = 1'b0;
                    mask_d = (st == ST_DESEL);
                end
                if (do_wr)
                    lock_d = 1'b1;
            end
            ST_DOZE:  st_d = doze_req ? ST_SLEEP : ST_DESEL;
            ST_SLEEP: st_d = doze_req ? ST_SLEEP : ST_WAKE;
            ST_WAKE:  st_d = doze_req ? ST_DOZE : ST_DESEL;
            default:  st_d = ST_DESEL;
        endcase
    end

    always_comb begin
        load     = new_ld && chosen;
        step     = !new_ld && in_burst && !step_n;
        wr_lanes = do_wr ? lanes_req : '0;
        rd_en    = (st == ST_READ) && !lock_q && !mask_q && !out_en_n;
    end
endmodule

// File: rtl/burst_sram_ft.sv
module burst_sram_ft
    import sram_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int LANES = 4,
    parameter int LW    = 9,
    localparam int AW   = $clog2(DEPTH),
    localparam int DW   = LANES * LW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             cpu_strobe_n,
    input  logic             ctl_strobe_n,
    input  logic             en_a_n,
    input  logic             en_b,
    input  logic             en_c_n,
    input  logic             step_n,
    input  logic             wr_all_n,
    input  logic             wr_lane_en_n,
    input  logic [LANES-1:0] lane_pick_n,
    input  logic             order_xor,
    input  logic             out_en_n,
    input  logic             doze_req,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             rdata_oe
);
    logic             ld_w, step_w, rd_w;
    logic [LANES-1:0] we_w;
    logic [AW-1:0]    cur_w, tgt_w;
    logic [DW-1:0]    q_w;
    sram_st_e         st_w;

    sram_ctrl #(.LANES(LANES)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
        .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n), .step_n(step_n),
        .wr_all_n(wr_all_n), .wr_lane_en_n(wr_lane_en_n), .lane_pick_n(lane_pick_n),
        .out_en_n(out_en_n), .doze_req(doze_req),
        .load(ld_w), .step(step_w), .wr_lanes(we_w), .rd_en(rd_w), .st(st_w)
    );

    sram_burst #(.AW(AW)) u_burst (
        .clk(clk), .rst_n(rst_n), .load(ld_w), .step(step_w),
        .order_xor(order_xor), .addr_in(addr),
        .cur_addr(cur_w), .tgt_addr(tgt_w)
    );

    sram_lanes #(.DEPTH(DEPTH), .LANES(LANES), .LW(LW)) u_mem (
        .clk(clk), .we(we_w), .waddr(tgt_w), .wdata(wdata),
        .raddr(cur_w), .rdata(q_w)
    );

    assign rdata_oe = rd_w;
    assign rdata    = rd_w ? q_w : '0;
endmodule

// File: rtl/sram_chk.sv
module sram_chk
    import sram_pkg::*;
#(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_strobe_n,
    input logic             ctl_strobe_n,
    input logic             en_a_n,
    input logic             en_b,
    input logic             en_c_n,
    input logic             wr_all_n,
    input logic             wr_lane_en_n,
    input logic [LANES-1:0] lane_pick_n,
    input logic             doze_req,
    input logic             rdata_oe,
    input sram_st_e         st
);
    logic awake, sel_ok, wr_ind;
    assign awake  = (st == ST_DESEL || st == ST_READ || st == ST_WRITE) && !doze_req;
    assign sel_ok = !en_a_n && en_b && !en_c_n;
    assign wr_ind = !wr_all_n || (!wr_lane_en_n && !(&lane_pick_n));

    a_r1_cpu_first: assert property (@(posedge clk) disable iff (!rst_n)
        (awake && !cpu_strobe_n && !ctl_strobe_n && sel_ok && wr_ind) |=> (st == ST_READ));

    a_r2_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        (awake && ((!cpu_strobe_n && !en_a_n) || !ctl_strobe_n) && !sel_ok)
        |=> (st == ST_DESEL && !rdata_oe));

    a_r3_cpu_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READ && !doze_req && en_a_n && ctl_strobe_n && !wr_ind) |=> (st == ST_READ));

    a_r10_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WRITE) |-> !rdata_oe);

    a_r11_first_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READ && $past(st) == ST_DESEL) |-> !rdata_oe);

    a_r12_asleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DOZE || st == ST_SLEEP || st == ST_WAKE) |-> !rdata_oe);

    a_r12_two_edges_in: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SLEEP) |-> ($past(st) == ST_DOZE || $past(st) == ST_SLEEP));
endmodule

bind burst_sram_ft sram_chk #(.LANES(LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
    .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n), .wr_all_n(wr_all_n),
    .wr_lane_en_n(wr_lane_en_n), .lane_pick_n(lane_pick_n), .doze_req(doze_req),
    .rdata_oe(rdata_oe), .st(st_w)
);

// File: tb/sim_burst_sram_ft.sv
`timescale 1ns/1ps
module sim_burst_sram_ft;
    localparam int DEPTH = 1024;
    localparam int AW    = 10;
    localparam int DW    = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          cpu_strobe_n, ctl_strobe_n, en_a_n, en_b, en_c_n, step_n;
    logic          wr_all_n, wr_lane_en_n, order_xor, out_en_n, doze_req;
    logic [3:0]    lane_pick_n;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_oe;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string cur_req = "R13";

    always #5 clk = ~clk;

    burst_sram_ft #(.DEPTH(DEPTH), .LANES(4), .LW(9)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cpu_strobe_n(cpu_strobe_n),
        .ctl_strobe_n(ctl_strobe_n), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
        .step_n(step_n), .wr_all_n(wr_all_n), .wr_lane_en_n(wr_lane_en_n),
        .lane_pick_n(lane_pick_n), .order_xor(order_xor), .out_en_n(out_en_n),
        .doze_req(doze_req), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    // ---------------- reference model ----------------
    logic [DW-1:0] ref_mem [DEPTH];
    int m_st = 0;            // 0 idle,1 read,2 write,3 doze,4 sleep,5 wake
    int m_base = 0, m_start = 0, m_k = 0;
    bit m_lock = 0, m_mask = 0;

    function automatic int m_addr();
        int lo;
        lo = order_xor ? (m_start ^ m_k) : ((m_start + m_k) % 4);
        return (m_base / 4) * 4 + lo;
    endfunction

    function automatic logic [DW-1:0] pat(int a);
        return {4'h9, 16'(a * 37 + 11), 16'(a)};
    endfunction

    task automatic m_write(int a, logic [3:0] ln);
        for (int i = 0; i < 4; i++)
            if (ln[i]) ref_mem[a][i*9 +: 9] = wdata[i*9 +: 9];
    endtask

    always @(posedge clk) begin
        logic [3:0] ln;
        bit cpu, ctl;
        if (!rst_n) begin
            m_st = 0; m_lock = 0; m_mask = 0; m_k = 0; m_base = 0; m_start = 0;
        end else begin
            ln = !wr_all_n ? 4'hF : (!wr_lane_en_n ? ~lane_pick_n : 4'h0);
            if (doze_req) begin
                m_mask = 0;
                m_st = (m_st == 3 || m_st == 4) ? 4 : 3;
            end else if (m_st == 3 || m_st == 5) begin
                m_st = 0; m_mask = 0;
            end else if (m_st == 4) begin
                m_st = 5;
            end else begin
                cpu = !cpu_strobe_n && !en_a_n;
                ctl = !ctl_strobe_n && !cpu;
                if (cpu || ctl) begin
                    if (!(!en_a_n && en_b && !en_c_n)) begin
                        m_st = 0; m_mask = 0;
                    end else begin
                        m_base = int'(addr); m_start = int'(addr) % 4; m_k = 0;
                        if (ctl && ln != 0) begin
                            m_write(int'(addr), ln); m_st = 2; m_lock = 1; m_mask = 0;
                        end else begin
                            m_mask = (m_st == 0); m_st = 1; m_lock = 0;
                        end
                    end
                end else if (m_st != 0) begin
                    m_mask = 0;
                    if (!step_n) m_k = (m_k + 1) % 4;
                    if (ln != 0) begin
                        m_write(m_addr(), ln); m_st = 2; m_lock = 1;
                    end else m_st = 1;
                end else m_mask = 0;
            end
        end
    end

    task automatic chk(string req, logic [DW:0] got, logic [DW:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
        end
    endtask

    // per-cycle comparison, 3 ns after the falling edge
    always @(negedge clk) begin
        bit e_oe;
        logic [DW-1:0] e_d;
        #3;
        if (rst_n) begin
            e_oe = (m_st == 1) && !m_lock && !m_mask && !out_en_n;
            e_d  = e_oe ? ref_mem[m_addr()] : '0;
            if (!$isunknown(e_d)) chk(cur_req, {rdata_oe, rdata}, {e_oe, e_d});
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick();
        @(negedge clk); #4;
    endtask

    task automatic idle();
        cpu_strobe_n = 1; ctl_strobe_n = 1; en_a_n = 0; en_b = 1; en_c_n = 0;
        step_n = 1; wr_all_n = 1; wr_lane_en_n = 1; lane_pick_n = 4'hF;
        out_en_n = 0; doze_req = 0;
    endtask

    task automatic ctl_write(int a, logic [DW-1:0] d);
        idle(); ctl_strobe_n = 0; wr_all_n = 0; addr = AW'(a); wdata = d; tick();
    endtask

    task automatic cpu_read(int a);
        idle(); cpu_strobe_n = 0; addr = AW'(a); tick();
    endtask

    task automatic burst_walk(int a, bit ox, string req);
        cur_req = req; order_xor = ox;
        cpu_read(a);
        for (int k = 0; k < 5; k++) begin
            int lo;
            lo = ox ? ((a % 4) ^ (k % 4)) : (((a % 4) + k) % 4);
            chk(req, {rdata_oe, rdata}, {1'b1, pat((a / 4) * 4 + lo)});
            idle(); step_n = 0; tick();
        end
    endtask

    initial begin
        idle(); order_xor = 1;
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 'x;
        repeat (3) tick();
        cur_req = "R13";
        chk("R13", {rdata_oe, rdata}, '0);
        rst_n = 1; tick();
        chk("R13", {rdata_oe, rdata}, '0);

        cur_req = "R5";
        for (int a = 0; a < 48; a++) ctl_write(a, pat(a));

        burst_walk(5, 1'b1, "R8");
        burst_walk(6, 1'b0, "R8");
        burst_walk(43, 1'b1, "R9");
        burst_walk(41, 1'b0, "R7");

        // suspend: address held while step_n high
        cur_req = "R7"; order_xor = 0;
        cpu_read(10); idle(); step_n = 1; tick();
        chk("R7", {rdata_oe, rdata}, {1'b1, pat(10)});
        idle(); step_n = 0; tick();
        chk("R7", {rdata_oe, rdata}, {1'b1, pat(11)});

        // lane picks: every pattern on its own word
        cur_req = "R6";
        for (int m = 0; m < 16; m++) begin
            idle(); ctl_strobe_n = 0; wr_lane_en_n = 0; lane_pick_n = ~4'(m);
            addr = AW'(64 + m); wdata = ~pat(64 + m);
            tick();
        end
        for (int m = 0; m < 16; m++) begin
            idle(); ctl_strobe_n = 0; wr_all_n = 0; addr = AW'(80 + m); wdata = pat(80 + m); tick();
            idle(); ctl_strobe_n = 0; wr_lane_en_n = 0; lane_pick_n = ~4'(m);
            addr = AW'(80 + m); wdata = ~pat(80 + m); tick();
        end
        for (int m = 0; m < 16; m++) begin
            logic [DW-1:0] e;
            e = pat(80 + m);
            for (int i = 0; i < 4; i++) if (m[i]) e[i*9 +: 9] = ~e[i*9 +: 9];
            cpu_read(80 + m);
            chk("R6", {rdata_oe, rdata}, {1'b1, e});
        end
        // global write overrides lane picks
        idle(); ctl_strobe_n = 0; wr_all_n = 0; wr_lane_en_n = 1; lane_pick_n = 4'hF;
        addr = 10'd100; wdata = 36'h123456789; tick();
        cpu_read(100);
        chk("R6", {rdata_oe, rdata}, {1'b1, 36'h123456789});

        // priority: both strobes with write inputs -> read, no write
        cur_req = "R1";
        idle(); cpu_strobe_n = 0; ctl_strobe_n = 0; wr_all_n = 0;
        addr = 10'd20; wdata = '0; tick();
        chk("R1", {rdata_oe, rdata}, {1'b1, pat(20)});

        // processor-started burst then write on the next cycle
        cur_req = "R4";
        idle(); cpu_strobe_n = 0; wr_all_n = 0; addr = 10'd21; wdata = 36'h0; tick();
        chk("R4", {rdata_oe, rdata}, {1'b1, pat(21)});
        idle(); wr_all_n = 0; wdata = 36'hABCDE0123; tick();
        chk("R10", {rdata_oe, rdata}, '0);
        idle(); tick();     // burst read after write: still off
        chk("R10", {rdata_oe, rdata}, '0);
        cpu_read(21);
        chk("R4", {rdata_oe, rdata}, {1'b1, 36'hABCDE0123});

        // extended burst write by controller
        cur_req = "R5"; order_xor = 0;
        ctl_write(28, 36'h111111111);
        idle(); step_n = 0; wr_all_n = 0; wdata = 36'h222222222; tick();
        cpu_read(29);
        chk("R5", {rdata_oe, rdata}, {1'b1, 36'h222222222});
        idle(); ctl_strobe_n = 0; addr = 10'd30; tick();   // controller read
        chk("R5", {rdata_oe, rdata}, {1'b1, pat(30)});

        // processor strobe ignored with en_a_n high: burst continues
        cur_req = "R3";
        cpu_read(32);
        idle(); cpu_strobe_n = 0; en_a_n = 1; addr = 10'd7; step_n = 0; tick();
        chk("R3", {rdata_oe, rdata}, {1'b1, pat(33)});

        // deselect, then first read cycle masked
        cur_req = "R2";
        idle(); ctl_strobe_n = 0; en_b = 0; addr = 10'd2; tick();
        chk("R2", {rdata_oe, rdata}, '0);
        idle(); en_b = 0; tick();
        chk("R2", {rdata_oe, rdata}, '0);
        cur_req = "R11";
        cpu_read(2);
        chk("R11", {rdata_oe, rdata}, '0);
        idle(); tick();
        chk("R11", {rdata_oe, rdata}, {1'b1, pat(2)});

        // sleep entry and exit
        cur_req = "R12";
        idle(); doze_req = 1; tick();
        doze_req = 1; cpu_strobe_n = 0; addr = 10'd3; tick();
        chk("R12", {rdata_oe, rdata}, '0);
        idle(); doze_req = 1; ctl_strobe_n = 0; wr_all_n = 0; addr = 10'd3; wdata = '0; tick();
        chk("R12", {rdata_oe, rdata}, '0);
        idle(); tick(); tick();
        cpu_read(3); idle(); tick();
        chk("R12", {rdata_oe, rdata}, {1'b1, pat(3)});

        repeat (3) tick();
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule